// File: doc/BRIEF.md
# Free-Running Compare Timer

A memory-mapped general-purpose timer for a single clock domain. A counter of `CNT_W` bits (32 by default) counts upward and wraps naturally. Each increment is driven by a tick chosen from one of three clock-enable inputs. A compare register sets a sticky match flag when the counter reaches its value. The counter is never restarted by a match. A registered, maskable level interrupt follows the flag.

Software configures the timer through a plain 32-bit register bus with address, write strobe, write data and combinational read data. The tick may be divided by a general prescaler. When the oscillator tick is selected and the fast-path enable is set, the oscillator tick goes through a separate 4-bit prescaler instead. To park the timer, software loads the compare register with a value a few counts behind the live count. No match then occurs until nearly a full counter wrap.

Top module: `fr_timer`

## Requirements
- R1: Register offsets (byte addresses, decoded on the low address bits) are: control 0x00, prescaler 0x04, status 0x08, interrupt enable 0x0C, compare 0x10, count 0x24. Control keeps bits 0 (run), 3 (keep counting in wait), 8:6 (source), 9 (free-run) and 10 (fast-path enable); its other bits read 0, so writing all ones reads back 0x000007C9. The prescaler keeps bits 15:0 (0x0000FFFF), interrupt enable keeps bit 0, and unmapped offsets read 0.
- R2: While running, the count advances by exactly one per selected tick. Source code 1 takes `tick_bus`, 2 takes `tick_per` and 5 takes `tick_osc`. Any other code produces no tick.
- R3: Prescaler bits 11:0 hold N. The selected tick is divided by N+1, and N=0 passes every tick.
- R4: With source 5 and control bit 10 set, `tick_osc` is divided by (prescaler bits 15:12)+1, and the general prescaler is bypassed. With bit 10 clear, source 5 uses the general prescaler.
- R5: With control bit 0 clear, the count (and the prescaler phase) goes to 0 on the next edge and stays there.
- R6: While `wait_req` is high, counting halts if control bit 3 is 0 and continues if it is 1.
- R7: Status bit 0 sets on the same edge at which the count takes the compare value. The count keeps advancing afterwards.
- R8: Writing status with bit 0 = 1 clears the flag. Writing 0 leaves it unchanged.
- R9: If a clearing write and a new match fall on the same edge, the flag ends set.
- R10: `irq` is the registered AND of the flag and interrupt-enable bit 0. It follows one cycle after either changes, so writing 0 to interrupt enable masks it.
- R11: With compare loaded as (count − 3), no match occurs over thousands of ticks.
- R12: The count is read-only, and writes to offset 0x24 do not change it.
- R13: After reset, every register, the count, the flag and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address of the register access |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| tick_bus | input | 1 | Bus-clock tick enable (source 1) |
| tick_per | input | 1 | Peripheral-clock tick enable (source 2) |
| tick_osc | input | 1 | Oscillator tick enable (source 5) |
| wait_req | input | 1 | System wait-mode request |
| irq | output | 1 | Level compare interrupt |

## Verification
The bench times the first visible flag exactly: the count must read the compare value at the same sample, and `irq` must rise only one sample later. An off-by-one match (comparing the old count), or a combinational interrupt, shows up there. It collides a clear write with a match on one edge, so a design that lets the clear win would drop a real event. It checks that dividers are exact over windows that are whole multiples of the divisor, and that the fast path ignores the general prescaler; a mis-routed tick source gives the wrong count delta. Parking with count−3 catches a design that matches on "greater or equal" instead of equality.

// File: rtl/fr_timer_pkg.sv
package fr_timer_pkg;
   localparam logic [7:0] OFF_CTRL = 8'h00;
   localparam logic [7:0] OFF_PRE  = 8'h04;
   localparam logic [7:0] OFF_STAT = 8'h08;
   localparam logic [7:0] OFF_IEN  = 8'h0C;
   localparam logic [7:0] OFF_CMP  = 8'h10;
   localparam logic [7:0] OFF_CNT  = 8'h24;

   localparam logic [2:0] SRC_BUS = 3'd1;
   localparam logic [2:0] SRC_PER = 3'd2;
   localparam logic [2:0] SRC_OSC = 3'd5;

   // field position of the fast-path divisor inside the prescaler word
   localparam int unsigned PRE24_LSB = 12;

   typedef struct packed {
      logic       path24;
      logic       freerun;
      logic [2:0] src;
      logic       waiten;
      logic       en;
   } ctrl_t;
endpackage

// File: rtl/fr_timer_div.sv
module fr_timer_div #(
   parameter int unsigned W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         tick_in,
   input  logic [W-1:0] div,
   output logic         tick_out
);
   logic [W-1:0] phase_q;
   logic         wrap;

   assign wrap     = (phase_q >= div);
   assign tick_out = tick_in && wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       phase_q <= '0;
      else if (clr)     phase_q <= '0;
      else if (tick_in) phase_q <= wrap ? '0 : phase_q + 1'b1;
   end
endmodule

// File: rtl/fr_timer_tick.sv
module fr_timer_tick
   import fr_timer_pkg::*;
#(
   parameter int unsigned PRE_W   = 12,
   parameter int unsigned PRE24_W = 4,
   parameter bit          HAS_24M = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               run,
   input  logic [2:0]         src,
   input  logic               path24,
   input  logic               tick_bus,
   input  logic               tick_per,
   input  logic               tick_osc,
   input  logic [PRE_W-1:0]   pre,
   input  logic [PRE24_W-1:0] pre24,
   output logic               tick
);
   logic raw, fast_sel, main_out, fast_out;

   always_comb begin
      unique case (src)
         SRC_BUS: raw = tick_bus;
         SRC_PER: raw = tick_per;
         SRC_OSC: raw = tick_osc;
         default: raw = 1'b0;
      endcase
   end

   assign fast_sel = HAS_24M && path24 && (src == SRC_OSC);

   fr_timer_div #(.W(PRE_W)) u_main (
      .clk(clk), .rst_n(rst_n), .clr(!en),
      .tick_in(run && raw && !fast_sel), .div(pre), .tick_out(main_out)
   );

   generate
      if (HAS_24M) begin : g_fast
         fr_timer_div #(.W(PRE24_W)) u_fast (
            .clk(clk), .rst_n(rst_n), .clr(!en),
            .tick_in(run && tick_osc && fast_sel), .div(pre24), .tick_out(fast_out)
         );
      end else begin : g_nofast
         assign fast_out = 1'b0;
      end
   endgenerate

   assign tick = main_out || fast_out;
endmodule

// File: rtl/fr_timer_core.sv
module fr_timer_core #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   input  logic [CNT_W-1:0] cmp,
   input  logic             clr_flag,
   output logic [CNT_W-1:0] cnt,
   output logic             flag
);
   logic [CNT_W-1:0] nxt;
   logic             hit;

   assign nxt = cnt + 1'b1;
   assign hit = tick && (nxt == cmp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (!en)  cnt <= '0;
      else if (tick) cnt <= nxt;
   end

   // a new match outranks a clearing write on the same edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag <= 1'b0;
      else if (hit)      flag <= 1'b1;
      else if (clr_flag) flag <= 1'b0;
   end
endmodule

// File: rtl/fr_timer.sv
module fr_timer
   import fr_timer_pkg::*;
#(
   parameter int unsigned CNT_W   = 32,
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned PRE_W   = 12,
   parameter int unsigned PRE24_W = 4,
   parameter bit          HAS_24M = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   input  logic              tick_bus,
   input  logic              tick_per,
   input  logic              tick_osc,
   input  logic              wait_req,
   output logic              irq
);
   localparam int unsigned RD_PAD = 32 - CNT_W;

   generate
      if (CNT_W < 8 || CNT_W > 32) begin : g_bad_cnt
         $error("fr_timer: CNT_W must lie in 8..32");
      end
      if (PRE_W < 1 || PRE_W > PRE24_LSB) begin : g_bad_pre
         $error("fr_timer: PRE_W must lie in 1..12");
      end
      if (PRE24_W < 1 || PRE24_W > 4) begin : g_bad_pre24
         $error("fr_timer: PRE24_W must lie in 1..4");
      end
      if (ADDR_W < 6) begin : g_bad_addr
         $error("fr_timer: ADDR_W must be at least 6");
      end
   endgenerate

   ctrl_t              ctrl_q;
   logic [PRE_W-1:0]   pre_q;
   logic [PRE24_W-1:0] pre24_q;
   logic               ie_q;
   logic [CNT_W-1:0]   cmp_q;
   logic [CNT_W-1:0]   cnt_q;
   logic               flag_q;
   logic               ctrl_en;
   logic               run, tick, clr_flag;
   logic               sel_ctrl, sel_pre, sel_stat, sel_ien, sel_cmp, sel_cnt;

   assign sel_ctrl = (addr == ADDR_W'(OFF_CTRL));
   assign sel_pre  = (addr == ADDR_W'(OFF_PRE));
   assign sel_stat = (addr == ADDR_W'(OFF_STAT));
   assign sel_ien  = (addr == ADDR_W'(OFF_IEN));
   assign sel_cmp  = (addr == ADDR_W'(OFF_CMP));
   assign sel_cnt  = (addr == ADDR_W'(OFF_CNT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         pre_q   <= '0;
         pre24_q <= '0;
         ie_q    <= 1'b0;
         cmp_q   <= '0;
      end else if (wr_en) begin
         if (sel_ctrl) begin
            ctrl_q.en      <= wdata[0];
            ctrl_q.waiten  <= wdata[3];
            ctrl_q.src     <= wdata[8:6];
            ctrl_q.freerun <= wdata[9];
            ctrl_q.path24  <= wdata[10];
         end
         if (sel_pre) begin
            pre_q   <= wdata[PRE_W-1:0];
            pre24_q <= wdata[PRE24_LSB +: PRE24_W];
         end
         if (sel_ien) ie_q  <= wdata[0];
         if (sel_cmp) cmp_q <= wdata[CNT_W-1:0];
      end
   end

   assign ctrl_en  = ctrl_q.en;
   assign run      = ctrl_q.en && !(wait_req && !ctrl_q.waiten);
   assign clr_flag = wr_en && sel_stat && wdata[0];

   fr_timer_tick #(.PRE_W(PRE_W), .PRE24_W(PRE24_W), .HAS_24M(HAS_24M)) u_tick (
      .clk(clk), .rst_n(rst_n), .en(ctrl_en), .run(run),
      .src(ctrl_q.src), .path24(ctrl_q.path24),
      .tick_bus(tick_bus), .tick_per(tick_per), .tick_osc(tick_osc),
      .pre(pre_q), .pre24(pre24_q), .tick(tick)
   );

   fr_timer_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .en(ctrl_en), .tick(tick),
      .cmp(cmp_q), .clr_flag(clr_flag), .cnt(cnt_q), .flag(flag_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= flag_q && ie_q;
   end

   logic [11:0] pre_rd;
   logic [3:0]  pre24_rd;
   assign pre_rd   = 12'(pre_q);
   assign pre24_rd = 4'(pre24_q);

   always_comb begin
      rdata = '0;
      if (sel_ctrl) rdata = {21'b0, ctrl_q.path24, ctrl_q.freerun, ctrl_q.src,
                             2'b0, ctrl_q.waiten, 2'b0, ctrl_q.en};
      if (sel_pre)  rdata = {16'b0, pre24_rd, pre_rd};
      if (sel_stat) rdata = {31'b0, flag_q};
      if (sel_ien)  rdata = {31'b0, ie_q};
      if (sel_cmp)  rdata = {{RD_PAD{1'b0}}, cmp_q};
      if (sel_cnt)  rdata = {{RD_PAD{1'b0}}, cnt_q};
   end
endmodule

// File: rtl/fr_timer_chk.sv
module fr_timer_chk #(
   parameter int unsigned CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] cmp,
   input logic             flag,
   input logic             ie,
   input logic             irq
);
   // R5
   a_r5_off_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt == '0));
   // R2
   a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));
   // R7
   a_r7_flag_on_match: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> (cnt == $past(cmp)));
   // R10
   a_r10_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && ie) |=> irq);
   // R10
   a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
      !(flag && ie) |=> !irq);
endmodule

bind fr_timer fr_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(ctrl_en), .cnt(cnt_q), .cmp(cmp_q),
   .flag(flag_q), .ie(ie_q), .irq(irq)
);

// File: tb/fr_timer_test.sv
module fr_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        tick_bus = 1'b0, tick_per = 1'b0, tick_osc = 1'b0, wait_req = 1'b0;
   logic        irq;
   int          checks = 0, errors = 0;

   localparam logic [7:0] A_CTRL = 8'h00, A_PRE = 8'h04, A_STAT = 8'h08,
                          A_IEN = 8'h0C, A_CMP = 8'h10, A_CNT = 8'h24;

   always #2.5 clk = ~clk;

   fr_timer uut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
      .rdata(rdata), .tick_bus(tick_bus), .tick_per(tick_per),
      .tick_osc(tick_osc), .wait_req(wait_req), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic delta(input logic [7:0] a, input int n, output logic [31:0] dl);
      logic [31:0] v0, v1;
      @(negedge clk);
      rd(a, v0);
      repeat (n) @(negedge clk);
      rd(a, v1);
      dl = v1 - v0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(A_CTRL, v); chk("R13 ctrl", v, 0);
      rd(A_PRE, v);  chk("R13 pre", v, 0);
      rd(A_STAT, v); chk("R13 stat", v, 0);
      rd(A_CMP, v);  chk("R13 cmp", v, 0);
      rd(A_CNT, v);  chk("R13 cnt", v, 0);
      chk("R13 irq", irq, 0);
   endtask

   task automatic t_regmap();
      logic [31:0] v;
      wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, v); chk("R1 ctrl mask", v, 32'h7C9);
      wr(A_CTRL, 0);
      wr(A_PRE, 32'hFFFF_FFFF);  rd(A_PRE, v);  chk("R1 pre mask", v, 32'hFFFF);
      wr(A_PRE, 0);
      wr(A_IEN, 32'hFFFF_FFFF);  rd(A_IEN, v);  chk("R1 ien mask", v, 1);
      wr(A_IEN, 0);
      wr(A_CMP, 32'hA5A5_1234);  rd(A_CMP, v);  chk("R1 cmp", v, 32'hA5A5_1234);
      wr(A_CMP, 0);
      rd(8'h30, v); chk("R1 unmapped", v, 0);
   endtask

   task automatic t_sources();
      logic [31:0] d;
      tick_bus = 1'b1;
      wr(A_CTRL, 32'h41);
      delta(A_CNT, 10, d); chk("R2 bus tick", d, 10);
      wr(A_CTRL, 32'h81);
      delta(A_CNT, 10, d); chk("R2 per idle", d, 0);
      tick_per = 1'b1;
      delta(A_CNT, 10, d); chk("R2 per tick", d, 10);
      wr(A_CTRL, 32'hC1);
      delta(A_CNT, 10, d); chk("R2 code 3 no tick", d, 0);
      tick_per = 1'b0;
   endtask

   task automatic t_prescale();
      logic [31:0] d;
      wr(A_PRE, 3);
      wr(A_CTRL, 32'h41);
      delta(A_CNT, 40, d); chk("R3 div4", d, 10);
      wr(A_PRE, 0);
      tick_osc = 1'b1;
      wr(A_PRE, 32'h7FFF);
      wr(A_CTRL, 32'h541);
      delta(A_CNT, 80, d); chk("R4 fast div8", d, 10);
      wr(A_PRE, 1);
      wr(A_CTRL, 32'h141);
      delta(A_CNT, 80, d); chk("R4 no fast uses general", d, 40);
      wr(A_PRE, 0);
      tick_osc = 1'b0;
   endtask

   task automatic t_disable();
      logic [31:0] v, d;
      wr(A_CTRL, 32'h41);
      repeat (5) @(negedge clk);
      wr(A_CTRL, 0);
      @(negedge clk);
      rd(A_CNT, v); chk("R5 cleared", v, 0);
      delta(A_CNT, 10, d); rd(A_CNT, v); chk("R5 stays zero", v, 0);
   endtask

   task automatic t_wait();
      logic [31:0] d;
      wait_req = 1'b1;
      wr(A_CTRL, 32'h41);
      delta(A_CNT, 10, d); chk("R6 halted in wait", d, 0);
      wr(A_CTRL, 32'h49);
      delta(A_CNT, 10, d); chk("R6 wait enabled", d, 10);
      wait_req = 1'b0;
      wr(A_CTRL, 0);
   endtask

   task automatic t_match();
      logic [31:0] v;
      bit seen = 0;
      wr(A_CTRL, 0);
      wr(A_STAT, 1);
      wr(A_CMP, 20);
      wr(A_IEN, 1);
      wr(A_CTRL, 32'h41);
      for (int i = 0; i < 100 && !seen; i++) begin
         rd(A_STAT, v);
         if (v[0]) begin
            seen = 1;
            rd(A_CNT, v); chk("R7 count at flag", v, 20);
            chk("R10 irq lags flag", irq, 0);
            @(negedge clk);
            chk("R10 irq raised", irq, 1);
            rd(A_CNT, v); chk("R7 keeps counting", v, 21);
         end else @(negedge clk);
      end
      chk("R7 flag seen", 32'(seen), 1);
   endtask

   task automatic t_clear();
      logic [31:0] v, c;
      tick_bus = 1'b0;
      wr(A_STAT, 0);
      rd(A_STAT, v); chk("R8 write 0 keeps flag", v, 1);
      // set-wins collision: stalled count, one tick lands with a clear write
      rd(A_CNT, c);
      wr(A_CMP, c + 1);
      @(negedge clk);
      tick_bus = 1'b1; addr = A_STAT; wdata = 1; wr_en = 1'b1;
      @(negedge clk);
      tick_bus = 1'b0; wr_en = 1'b0;
      rd(A_STAT, v); chk("R9 set wins", v, 1);
      rd(A_CNT, v);  chk("R9 count advanced", v, c + 1);
      wr(A_IEN, 0);
      @(negedge clk);
      chk("R10 masked", irq, 0);
      wr(A_IEN, 1);
      @(negedge clk);
      chk("R10 unmasked", irq, 1);
      wr(A_STAT, 1);
      rd(A_STAT, v); chk("R8 write 1 clears", v, 0);
      @(negedge clk);
      chk("R10 irq drops", irq, 0);
   endtask

   task automatic t_park();
      logic [31:0] v;
      bit hit = 0;
      tick_bus = 1'b1;
      rd(A_CNT, v);
      wr(A_CMP, v - 3);
      wr(A_STAT, 1);
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         rd(A_STAT, v);
         if (v[0]) hit = 1;
      end
      chk("R11 parked no match", 32'(hit), 0);
   endtask

   task automatic t_readonly();
      logic [31:0] a, b;
      wr(A_CTRL, 32'hC1);
      @(negedge clk);
      rd(A_CNT, a);
      wr(A_CNT, 32'h0001_2345);
      rd(A_CNT, b); chk("R12 count read-only", b, a);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regmap();
      t_sources();
      t_prescale();
      t_disable();
      t_wait();
      t_match();
      t_clear();
      t_park();
      t_readonly();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule